// File: doc/BRIEF.md
# Call/Return Stack Sequencer

This block carries out the stack side of control flow for a machine with 16-bit addresses and 8-bit data. It owns the program counter (PC) and the stack pointer (SP). It runs calls, returns, restarts, pushes, pops, the exchange of HL with the top of the stack, SP load from HL, and jumps. It reaches a byte-wide synchronous memory through one port. Instruction decode, condition evaluation and the ALU sit outside. The decoder supplies a 4-bit command code, a 16-bit operand and a `take` flag that holds the outcome of the condition.

The decoder has already fetched the opcode when it issues a command. PC therefore points just past the opcode, which is at the first operand byte for three-byte instructions. A command is accepted when `cmd_valid` is high and the block is not busy. Memory-free commands finish one cycle after acceptance. Stack commands take one cycle per memory access. `done` pulses for one cycle when a command finishes. In that cycle `pc`, `sp` and `pop_data` already hold the new values.

Top module: `stack_seq`

## Requirements
- R1: After reset, `pc` and `sp` are 0 and `busy`, `done` and `mem_we` are low.
- R2: Command 3 (push) writes operand bits 15:8 to address SP-1 in the first busy cycle. It writes operand bits 7:0 to address SP-2 in the next cycle. SP ends at SP-2 and `done` is high in the cycle after that.
- R3: Command 4 (pop) reads the byte at SP as the low byte and the byte at SP+1 as the high byte. It returns {high, low} on `pop_data`, leaves SP at SP+2, makes no write, and raises `done` four cycles after acceptance.
- R4: Command 0 (call) with `take` high pushes PC+2 in the same byte order as R2 and then loads PC with the operand. PC is unchanged while the pushes are in progress.
- R5: Command 2 (restart) pushes the current PC in the same byte order as R2. It then loads PC with operand bits 7:0 ANDed with 0x38, with the upper byte zero.
- R6: Command 0 (call) or command 8 (jump) with `take` low advances PC by 2 with no memory write, leaves SP unchanged, and raises `done` one cycle after acceptance. Command 8 with `take` high loads PC with the operand in the same cycle.
- R7: Command 1 (return) with `take` high pops a word as in R3 into PC. With `take` low it leaves PC and SP unchanged, makes no write, and finishes in one cycle.
- R8: Command 5 (exchange) returns the old word at SP (low) and SP+1 (high) on `pop_data`. It writes operand bits 7:0 to SP and bits 15:8 to SP+1, leaves SP unchanged, and raises `done` five cycles after acceptance.
- R9: Command 6 copies the operand into SP and command 7 copies the operand into PC. Each finishes in one cycle.
- R10: All SP and PC arithmetic wraps modulo 2^16. A push from SP=0x0001 writes to 0x0000 and then 0xFFFF.
- R11: `done` is a single-cycle pulse during which `busy` is low. A `cmd_valid` seen while busy has no effect. Memory writes occur only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Command code |
| cmd_arg | input | 16 | Operand: target, push data, HL value or restart opcode |
| cmd_take | input | 1 | Condition outcome for call, jump and return |
| busy | output | 1 | Sequence in progress; commands ignored |
| done | output | 1 | One-cycle completion pulse |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| pop_data | output | 16 | Word read by pop or exchange |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Read data, valid the cycle after its address |

## Verification
Each command is timed from its accepting edge. `done` is due 1 cycle later for memory-free commands, 3 cycles later for push, call and restart, 4 for pop and taken return, and 5 for exchange. The bench drives and samples on the falling edge. It counts the falling edges from the accepting edge until `done` and compares that count with these exact figures. It also logs every write the block makes and compares the address and data of each write in issue order, as well as the total number of writes. A command injected during a busy cycle and dropped before the `done` cycle shows through an unchanged `pc`.

// File: rtl/stack_seq.sv
module stack_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [3:0]  cmd_op,
  input  logic [15:0] cmd_arg,
  input  logic        cmd_take,
  output logic        busy,
  output logic        done,
  output logic [15:0] pc,
  output logic [15:0] sp,
  output logic [15:0] pop_data,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  input  logic [7:0]  mem_rdata
);
  localparam logic [3:0] OP_CALL = 4'd0, OP_RET = 4'd1, OP_RST = 4'd2, OP_PUSH = 4'd3,
                         OP_POP  = 4'd4, OP_XCH = 4'd5, OP_LDSP = 4'd6, OP_LDPC = 4'd7,
                         OP_JUMP = 4'd8;
  localparam logic [7:0] VEC_MASK = 8'h38;

  typedef enum logic [3:0] {
    S_IDLE, S_WHI, S_WLO, S_RLO, S_RHI, S_RFIN, S_XR0, S_XR1, S_XW0, S_XW1
  } step_t;

  step_t       st;
  logic [15:0] word, tgt;
  logic        ld_pc;
  logic        accept;

  assign busy   = (st != S_IDLE);
  assign accept = cmd_valid && !busy;

  always_comb begin
    mem_addr  = sp;
    mem_wdata = 8'h00;
    mem_we    = 1'b0;
    case (st)
      S_WHI: begin mem_addr = sp - 16'd1; mem_we = 1'b1; mem_wdata = word[15:8]; end
      S_WLO: begin mem_addr = sp - 16'd1; mem_we = 1'b1; mem_wdata = word[7:0];  end
      S_XR1: mem_addr = sp + 16'd1;
      S_XW0: begin mem_we = 1'b1; mem_wdata = word[7:0]; end
      S_XW1: begin mem_addr = sp + 16'd1; mem_we = 1'b1; mem_wdata = word[15:8]; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      pc       <= 16'h0000;
      sp       <= 16'h0000;
      word     <= 16'h0000;
      tgt      <= 16'h0000;
      ld_pc    <= 1'b0;
      done     <= 1'b0;
      pop_data <= 16'h0000;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          ld_pc <= 1'b0;
          case (cmd_op)
            OP_CALL: if (cmd_take) begin
                       word <= pc + 16'd2; tgt <= cmd_arg; ld_pc <= 1'b1; st <= S_WHI;
                     end else begin
                       pc <= pc + 16'd2; done <= 1'b1;
                     end
            OP_JUMP: begin
                       pc   <= cmd_take ? cmd_arg : pc + 16'd2;
                       done <= 1'b1;
                     end
            OP_RST:  begin
                       word <= pc; tgt <= {8'h00, cmd_arg[7:0] & VEC_MASK};
                       ld_pc <= 1'b1; st <= S_WHI;
                     end
            OP_PUSH: begin word <= cmd_arg; st <= S_WHI; end
            OP_RET:  if (cmd_take) begin ld_pc <= 1'b1; st <= S_RLO; end
                     else done <= 1'b1;
            OP_POP:  st <= S_RLO;
            OP_XCH:  begin word <= cmd_arg; st <= S_XR0; end
            OP_LDSP: begin sp <= cmd_arg; done <= 1'b1; end
            OP_LDPC: begin pc <= cmd_arg; done <= 1'b1; end
            default: done <= 1'b1;
          endcase
        end
        S_WHI: begin sp <= sp - 16'd1; st <= S_WLO; end
        S_WLO: begin
          sp <= sp - 16'd1;
          if (ld_pc) pc <= tgt;
          done <= 1'b1;
          st   <= S_IDLE;
        end
        S_RLO: begin sp <= sp + 16'd1; st <= S_RHI; end
        S_RHI: begin sp <= sp + 16'd1; pop_data[7:0] <= mem_rdata; st <= S_RFIN; end
        S_RFIN: begin
          pop_data[15:8] <= mem_rdata;
          if (ld_pc) pc <= {mem_rdata, pop_data[7:0]};
          done <= 1'b1;
          st   <= S_IDLE;
        end
        S_XR0: st <= S_XR1;
        S_XR1: begin pop_data[7:0] <= mem_rdata; st <= S_XW0; end
        S_XW0: begin pop_data[15:8] <= mem_rdata; st <= S_XW1; end
        S_XW1: begin done <= 1'b1; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        mem_we,
  input logic [15:0] mem_addr,
  input logic [15:0] pc,
  input logic [15:0] sp
);
  // R11
  wr_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> busy);
  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R10
  sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (sp == $past(sp) || sp == $past(sp) + 16'd1 || sp == $past(sp) - 16'd1));
  // R4
  pc_start_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $stable(pc));
  // R8
  wr_near_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr == sp - 16'd1 || mem_addr == sp || mem_addr == sp + 16'd1));
endmodule

bind stack_seq stack_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .mem_we(mem_we), .mem_addr(mem_addr), .pc(pc), .sp(sp)
);

// File: tb/sim_stack_seq.sv
module sim_stack_seq;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_take = 1'b0;
  logic [3:0]  cmd_op = 4'd0;
  logic [15:0] cmd_arg = 16'h0;
  logic        busy, done, mem_we;
  logic [15:0] pc, sp, pop_data, mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  int tests = 0, fails = 0;
  logic [7:0]  bmem [0:255];
  logic [15:0] wa [0:7];
  logic [7:0]  wd [0:7];
  int wn = 0;
  int lat;

  always #5 clk = ~clk;

  stack_seq u0 (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .cmd_take(cmd_take), .busy(busy), .done(done), .pc(pc), .sp(sp),
    .pop_data(pop_data), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata));

  always @(posedge clk) begin
    mem_rdata <= bmem[mem_addr[7:0]];
    if (mem_we) begin
      bmem[mem_addr[7:0]] <= mem_wdata;
      if (wn < 8) begin wa[wn] <= mem_addr; wd[wn] <= mem_wdata; end
      wn <= wn + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [15:0] arg, input logic tk,
                       input bit inject);
    @(negedge clk);
    wn = 0;
    cmd_op = op; cmd_arg = arg; cmd_take = tk; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 1;
    if (inject && busy) begin
      cmd_op = 4'd7; cmd_arg = 16'h2222; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      lat++;
    end
    while (!done && lat < 20) begin @(negedge clk); lat++; end
  endtask

  task automatic chk_wr(input string req, input int i, input logic [15:0] a, input logic [7:0] d);
    chk(req, wa[i], a);
    chk(req, wd[i], d);
  endtask

  task automatic t_reset;
    chk("R1 pc", pc, 0); chk("R1 sp", sp, 0);
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 we", mem_we, 0);
  endtask

  task automatic t_loads;
    issue(4'd6, 16'h8010, 1'b0, 0);
    chk("R9 sp", sp, 16'h8010); chk("R9 lat", lat, 1);
    issue(4'd7, 16'h1234, 1'b0, 0);
    chk("R9 pc", pc, 16'h1234); chk("R9 lat", lat, 1);
  endtask

  task automatic t_push_pop;
    issue(4'd3, 16'hA1B2, 1'b0, 0);
    chk("R2 lat", lat, 3); chk("R2 nwr", wn, 2);
    chk_wr("R2 hi", 0, 16'h800F, 8'hA1); chk_wr("R2 lo", 1, 16'h800E, 8'hB2);
    chk("R2 sp", sp, 16'h800E);
    @(negedge clk); chk("R11 pulse", done, 0);
    issue(4'd4, 16'h0, 1'b0, 0);
    chk("R3 lat", lat, 4); chk("R3 data", pop_data, 16'hA1B2);
    chk("R3 sp", sp, 16'h8010); chk("R3 nwr", wn, 0);
  endtask

  task automatic t_call_ret;
    issue(4'd0, 16'h4000, 1'b1, 0);
    chk("R4 lat", lat, 3); chk("R4 pc", pc, 16'h4000); chk("R4 sp", sp, 16'h800E);
    chk_wr("R4 hi", 0, 16'h800F, 8'h12); chk_wr("R4 lo", 1, 16'h800E, 8'h36);
    issue(4'd1, 16'h0, 1'b0, 0);
    chk("R7 untaken lat", lat, 1); chk("R7 untaken pc", pc, 16'h4000);
    chk("R7 untaken sp", sp, 16'h800E); chk("R7 untaken nwr", wn, 0);
    issue(4'd1, 16'h0, 1'b1, 0);
    chk("R7 lat", lat, 4); chk("R7 pc", pc, 16'h1236); chk("R7 sp", sp, 16'h8010);
  endtask

  task automatic t_restart;
    issue(4'd2, 16'h00D7, 1'b0, 0);
    chk("R5 lat", lat, 3); chk("R5 pc", pc, 16'h0010); chk("R5 sp", sp, 16'h800E);
    chk_wr("R5 hi", 0, 16'h800F, 8'h12); chk_wr("R5 lo", 1, 16'h800E, 8'h36);
  endtask

  task automatic t_untaken;
    issue(4'd0, 16'h5555, 1'b0, 0);
    chk("R6 call pc", pc, 16'h0012); chk("R6 call lat", lat, 1);
    chk("R6 call nwr", wn, 0); chk("R6 call sp", sp, 16'h800E);
    issue(4'd8, 16'h5555, 1'b0, 0);
    chk("R6 jump pc", pc, 16'h0014);
    issue(4'd8, 16'hBEEF, 1'b1, 0);
    chk("R6 jump taken pc", pc, 16'hBEEF); chk("R6 jump lat", lat, 1);
  endtask

  task automatic t_exchange;
    issue(4'd5, 16'h5566, 1'b0, 0);
    chk("R8 lat", lat, 5); chk("R8 data", pop_data, 16'h1236);
    chk("R8 sp", sp, 16'h800E); chk("R8 nwr", wn, 2);
    chk_wr("R8 lo", 0, 16'h800E, 8'h66); chk_wr("R8 hi", 1, 16'h800F, 8'h55);
  endtask

  task automatic t_wrap;
    issue(4'd6, 16'h0001, 1'b0, 0);
    issue(4'd3, 16'h7788, 1'b0, 0);
    chk_wr("R10 hi", 0, 16'h0000, 8'h77); chk_wr("R10 lo", 1, 16'hFFFF, 8'h88);
    chk("R10 sp", sp, 16'hFFFF);
    issue(4'd4, 16'h0, 1'b0, 0);
    chk("R10 pop", pop_data, 16'h7788); chk("R10 sp back", sp, 16'h0001);
  endtask

  task automatic t_ignore;
    issue(4'd3, 16'h1111, 1'b0, 1);
    chk("R11 ignored pc", pc, 16'hBEEF); chk("R11 lat", lat, 3);
    chk("R11 busy at done", busy, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_loads;
    t_push_pop;
    t_call_ret;
    t_restart;
    t_untaken;
    t_exchange;
    t_wrap;
    t_ignore;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule